// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block takes received Ethernet frames from a byte stream and places each one into a memory buffer. The buffer is named by a descriptor in a ring held in memory. The stream carries a byte per beat, a last-byte marker and a CRC-good flag that is valid with the last byte. The MAC front end has already computed the CRC and filtered the addresses. For each frame the engine first reads a two-word descriptor at the current ring slot, then packs the payload little-endian into 32-bit words and writes them to the buffer. It closes the slot by writing its first word back with the byte count and clearing ownership. It then steps the ring pointer, sets a sticky receive status bit and, if both enables allow it, emits a one-cycle interrupt pulse.

The ring pointer is one 32-bit value. Bits 31:10 are a fixed base and bits 9:0 are a byte offset into the ring. Each slot is 8 bytes, so the offset steps by 8 and returns to 0 after slot 0x3F8 or when a slot carries its wrap flag. Memory is reached through one request/grant port. `mem_req` is held, with stable address, direction and write data, until `mem_gnt` is high for one cycle. For reads, `mem_rdata` is valid in that grant cycle.

The controller is a single state machine with these states:
- IDLE: waits for a first byte.
  - IDLE→DISCARD when receive is disabled.
  - IDLE→FETCH_CTL otherwise.
- FETCH_CTL: reads descriptor word 0. FETCH_CTL→FETCH_BUF on grant.
- FETCH_BUF: reads descriptor word 1.
  - FETCH_BUF→STREAM on grant when the slot is enabled.
  - FETCH_BUF→DISCARD on grant when it is not.
- STREAM: accepts bytes. STREAM→STORE when a word fills, or at the last byte while bytes are pending.
- STORE: writes one packed word.
  - STORE→STREAM on grant when the frame is not over.
  - STORE→CLOSE_CTL on grant after the last byte, if the CRC was good.
  - STORE→IDLE on grant after the last byte, if the CRC was bad.
  - A truncated frame whose last byte arrives with no pending bytes goes straight from STREAM to CLOSE_CTL or IDLE by the same CRC rule.
- DISCARD: swallows bytes until the last one. DISCARD→IDLE at the last byte.
- CLOSE_CTL: writes descriptor word 0. CLOSE_CTL→CLOSE_BUF on grant.
- CLOSE_BUF: writes descriptor word 1. CLOSE_BUF→NOTIFY on grant.
- NOTIFY: steps the pointer, sets status and raises the optional pulse. NOTIFY→IDLE always.

Top module: `rxring_dma`

## Requirements
- R1: While `rx_enable` is low when a frame starts, the whole frame is accepted and dropped. The engine issues no memory request, and the pointer and status do not change.
- R2: A frame starts with a read of the slot at `{ring_ptr[31:10], ring_ptr[9:0]}` and then a read at that address plus 4. If bit 11 (enable) of the first word is 0, the frame is dropped with no write, and the pointer and status do not change.
- R3: Byte i of a frame goes to buffer address (word1 with bits 1:0 cleared) + i. It sits in bits 8*(i mod 4)+7 down to 8*(i mod 4) of its word. Lanes past the frame end in the final word are written as zero. Every memory address has bits 1:0 equal to zero.
- R4: A frame whose `s_crc_ok` is low at the last byte leaves the descriptor unwritten. The pointer, status and interrupt do not change.
- R5: The written-back word 0 holds the stored byte count in bits 10:0, bit 13 copied from the fetched word 0, and bit 15 as the too-long flag. Every other bit, including enable (11) and wrap (12), is zero. The written-back word 1 is the fetched buffer address with bits 1:0 zero.
- R6: After a stored frame, the offset becomes 0 if the fetched word 0 had bit 12 set or the offset was 0x3F8. Otherwise it grows by 8. The base never changes except through `ring_ptr_wr`, which loads all 32 bits.
- R7: `rx_status` is set by each stored frame and stays set until `rx_status_clr`. A set in the same cycle wins over the clear.
- R8: After a stored frame, `irq_pulse` is high for exactly one cycle if and only if bit 13 of the fetched word 0 and `irq_enable` are both 1.
- R9: Only the first 2047 bytes of a longer frame are stored. The length field then reads 2047 and bit 15 is set.
- R10: After reset, `ring_ptr` is 0, and `rx_status`, `irq_pulse`, `mem_req` and `s_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receive enable, sampled when a frame starts |
| irq_enable | input | 1 | Global receive interrupt enable |
| ring_ptr_wr | input | 1 | Load strobe for the ring pointer |
| ring_ptr_wdata | input | 32 | Value to load (base in 31:10, offset in 9:0) |
| ring_ptr | output | 32 | Current ring pointer |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Last byte of the frame |
| s_crc_ok | input | 1 | CRC good, valid with `s_last` |
| s_ready | output | 1 | Stream byte accepted when high with `s_valid` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request granted this cycle |
| mem_rdata | input | 32 | Read data, valid with grant |
| rx_status | output | 1 | Sticky frame-received flag |
| rx_status_clr | input | 1 | Clears `rx_status` |
| irq_pulse | output | 1 | One-cycle receive interrupt |

## Verification
The assertions watch, on every cycle, the properties that hold regardless of frame content:
- the memory request holds its address and direction until granted;
- addresses stay word aligned;
- the stream is never accepted while a memory request is open;
- the interrupt is a single-cycle pulse that always leaves the status bit set;
- the pointer never moves other than by a load, a step of 8 or a return to offset 0.

The bench scenarios cover what depends on data held in memory:
- the little-endian packing and zero fill of the last word;
- the exact written-back descriptor words;
- drops for a disabled receiver, a disowned slot or a bad CRC;
- the two wrap causes;
- the gating of the interrupt by both enables;
- truncation at 2047 bytes.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

    localparam int LEN_W      = 11;
    localparam int BIT_OWN    = 11;
    localparam int BIT_LAST   = 12;
    localparam int BIT_NOTIFY = 13;
    localparam int BIT_LONG   = 15;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH_CTL,
        ST_FETCH_BUF,
        ST_STREAM,
        ST_STORE,
        ST_DISCARD,
        ST_CLOSE_CTL,
        ST_CLOSE_BUF,
        ST_NOTIFY
    } rx_state_e;

    // Word 0 as written back when a slot is closed: ownership and wrap cleared.
    function automatic logic [31:0] close_word(input logic [LEN_W-1:0] len,
                                               input logic notify,
                                               input logic too_long);
        logic [31:0] w;
        w               = '0;
        w[LEN_W-1:0]    = len;
        w[BIT_NOTIFY]   = notify;
        w[BIT_LONG]     = too_long;
        return w;
    endfunction

endpackage

// File: rtl/rxring_ptr.sv
module rxring_ptr #(
    parameter int AW    = 32,
    parameter int OFS_W = 10,
    parameter int STEP  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          advance,
    input  logic          wrap_req,
    output logic [AW-1:0] ptr
);
    localparam int BASE_W = AW - OFS_W;
    localparam logic [OFS_W-1:0] OFS_STEP = OFS_W'(STEP);
    localparam logic [OFS_W-1:0] OFS_LAST = OFS_W'((1 << OFS_W) - STEP);

    logic [BASE_W-1:0] base_q;
    logic [OFS_W-1:0]  off_q;
    logic [OFS_W-1:0]  off_next;

    always_comb begin
        if (wrap_req || off_q == OFS_LAST) off_next = '0;
        else                                off_next = off_q + OFS_STEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            off_q  <= '0;
        end else if (load) begin
            base_q <= load_val[AW-1:OFS_W];
            off_q  <= load_val[OFS_W-1:0];
        end else if (advance) begin
            off_q  <= off_next;
        end
    end

    assign ptr = {base_q, off_q};
endmodule

// File: rtl/rxring_pack.sv
module rxring_pack #(
    parameter int DW    = 32,
    parameter int LEN_W = rxring_pkg::LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              take,
    input  logic [7:0]        byte_in,
    input  logic              flush,
    output logic [DW-1:0]     word,
    output logic [$clog2(DW/8+1)-1:0] fill,
    output logic              room,
    output logic [LEN_W-1:0]  count,
    output logic              trunc
);
    localparam int LANES  = DW / 8;
    localparam int FILL_W = $clog2(LANES + 1);
    localparam logic [LEN_W-1:0] MAX_LEN = {LEN_W{1'b1}};

    logic [FILL_W-1:0] fill_q;
    logic [LEN_W-1:0]  count_q;
    logic              trunc_q;
    logic              store;

    assign room  = (count_q != MAX_LEN);
    assign store = take && room;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 lane_q <= '0;
            else if (start || flush)                    lane_q <= '0;
            else if (store && fill_q == FILL_W'(g))     lane_q <= byte_in;
        end
        assign word[g*8 +: 8] = lane_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q  <= '0;
            count_q <= '0;
            trunc_q <= 1'b0;
        end else if (start) begin
            fill_q  <= '0;
            count_q <= '0;
            trunc_q <= 1'b0;
        end else begin
            if (flush)            fill_q  <= '0;
            else if (store)       fill_q  <= fill_q + 1'b1;
            if (store)            count_q <= count_q + 1'b1;
            if (take && !room)    trunc_q <= 1'b1;
        end
    end

    assign fill  = fill_q;
    assign count = count_q;
    assign trunc = trunc_q;
endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
    import rxring_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int FILL_W = $clog2(DW/8 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              irq_enable,
    input  logic              s_valid,
    input  logic              s_last,
    input  logic              s_crc_ok,
    output logic              s_ready,
    input  logic [AW-1:0]     slot_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_gnt,
    input  logic [DW-1:0]     mem_rdata,
    output logic              pk_start,
    output logic              pk_take,
    output logic              pk_flush,
    input  logic [DW-1:0]     pk_word,
    input  logic [FILL_W-1:0] pk_fill,
    input  logic              pk_room,
    input  logic [LEN_W-1:0]  pk_count,
    input  logic              pk_trunc,
    output logic              ptr_advance,
    output logic              ptr_wrap,
    input  logic              status_clr,
    output logic              status,
    output logic              irq_pulse
);
    localparam int LANES = DW / 8;
    localparam logic [AW-1:0] WORD_BYTES = AW'(DW / 8);

    rx_state_e state_q, state_d;

    logic [AW-1:0] slot_q;
    logic [AW-1:0] buf_q;
    logic [AW-1:0] wptr_q;
    logic          own_q, wrap_q, notify_q;
    logic          last_q, crc_q;
    logic          status_q;
    logic          word_full;
    logic          frame_end;
    logic          unused_rdata;

    assign unused_rdata = ^mem_rdata[1:0];
    assign word_full    = pk_room && (pk_fill == FILL_W'(LANES - 1));
    assign frame_end    = s_valid && s_last;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (s_valid) state_d = rx_enable ? ST_FETCH_CTL : ST_DISCARD;
            ST_FETCH_CTL: if (mem_gnt) state_d = ST_FETCH_BUF;
            ST_FETCH_BUF: if (mem_gnt) state_d = own_q ? ST_STREAM : ST_DISCARD;
            ST_STREAM: begin
                if (frame_end) begin
                    if (pk_room || pk_fill != '0) state_d = ST_STORE;
                    else                           state_d = s_crc_ok ? ST_CLOSE_CTL : ST_IDLE;
                end else if (s_valid && word_full) begin
                    state_d = ST_STORE;
                end
            end
            ST_STORE: begin
                if (mem_gnt) begin
                    if (!last_q)    state_d = ST_STREAM;
                    else if (crc_q) state_d = ST_CLOSE_CTL;
                    else            state_d = ST_IDLE;
                end
            end
            ST_DISCARD:   if (frame_end) state_d = ST_IDLE;
            ST_CLOSE_CTL: if (mem_gnt) state_d = ST_CLOSE_BUF;
            ST_CLOSE_BUF: if (mem_gnt) state_d = ST_NOTIFY;
            ST_NOTIFY:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs decoded from the current state.
    always_comb begin
        s_ready     = 1'b0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = slot_q;
        mem_wdata   = '0;
        pk_take     = 1'b0;
        ptr_advance = 1'b0;
        ptr_wrap    = 1'b0;
        irq_pulse   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FETCH_CTL: begin
                mem_req  = 1'b1;
            end
            ST_FETCH_BUF: begin
                mem_req  = 1'b1;
                mem_addr = slot_q + WORD_BYTES;
            end
            ST_STREAM: begin
                s_ready  = 1'b1;
                pk_take  = s_valid;
            end
            ST_STORE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wptr_q;
                mem_wdata = pk_word;
            end
            ST_DISCARD: begin
                s_ready  = 1'b1;
            end
            ST_CLOSE_CTL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = DW'(close_word(pk_count, notify_q, pk_trunc));
            end
            ST_CLOSE_BUF: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = slot_q + WORD_BYTES;
                mem_wdata = DW'(buf_q);
            end
            ST_NOTIFY: begin
                ptr_advance = 1'b1;
                ptr_wrap    = wrap_q;
                irq_pulse   = notify_q && irq_enable;
            end
            default: ;
        endcase
    end

    assign pk_start = (state_q == ST_FETCH_BUF) && mem_gnt;
    assign pk_flush = (state_q == ST_STORE) && mem_gnt;

    // Per-frame context captured from the descriptor and the stream.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q   <= '0;
            buf_q    <= '0;
            wptr_q   <= '0;
            own_q    <= 1'b0;
            wrap_q   <= 1'b0;
            notify_q <= 1'b0;
            last_q   <= 1'b0;
            crc_q    <= 1'b0;
        end else begin
            if (state_q == ST_IDLE) slot_q <= slot_addr;
            if (state_q == ST_FETCH_CTL && mem_gnt) begin
                own_q    <= mem_rdata[BIT_OWN];
                wrap_q   <= mem_rdata[BIT_LAST];
                notify_q <= mem_rdata[BIT_NOTIFY];
            end
            if (pk_start) begin
                buf_q  <= {mem_rdata[AW-1:2], 2'b00};
                wptr_q <= {mem_rdata[AW-1:2], 2'b00};
                last_q <= 1'b0;
            end
            if (pk_flush) wptr_q <= wptr_q + WORD_BYTES;
            if (state_q == ST_STREAM && frame_end) begin
                last_q <= 1'b1;
                crc_q  <= s_crc_ok;
            end
        end
    end

    // Sticky receive status; a set beats a clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     status_q <= 1'b0;
        else if (state_q == ST_NOTIFY)  status_q <= 1'b1;
        else if (status_clr)            status_q <= 1'b0;
    end

    assign status = status_q;
endmodule

// File: rtl/rxring_dma.sv
module rxring_dma #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int OFS_W = 10,
    parameter int SLOT  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_enable,
    input  logic          irq_enable,
    input  logic          ring_ptr_wr,
    input  logic [AW-1:0] ring_ptr_wdata,
    output logic [AW-1:0] ring_ptr,
    input  logic          s_valid,
    input  logic [7:0]    s_data,
    input  logic          s_last,
    input  logic          s_crc_ok,
    output logic          s_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic [DW-1:0] mem_rdata,
    output logic          rx_status,
    input  logic          rx_status_clr,
    output logic          irq_pulse
);
    localparam int LEN_W  = rxring_pkg::LEN_W;
    localparam int FILL_W = $clog2(DW/8 + 1);

    logic              pk_start, pk_take, pk_flush, pk_room, pk_trunc;
    logic [DW-1:0]     pk_word;
    logic [FILL_W-1:0] pk_fill;
    logic [LEN_W-1:0]  pk_count;
    logic              ptr_advance, ptr_wrap;

    rxring_ptr #(.AW(AW), .OFS_W(OFS_W), .STEP(SLOT)) ptr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ring_ptr_wr),
        .load_val (ring_ptr_wdata),
        .advance  (ptr_advance),
        .wrap_req (ptr_wrap),
        .ptr      (ring_ptr)
    );

    rxring_pack #(.DW(DW), .LEN_W(LEN_W)) pack_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (pk_start),
        .take    (pk_take),
        .byte_in (s_data),
        .flush   (pk_flush),
        .word    (pk_word),
        .fill    (pk_fill),
        .room    (pk_room),
        .count   (pk_count),
        .trunc   (pk_trunc)
    );

    rxring_ctrl #(.AW(AW), .DW(DW), .FILL_W(FILL_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_enable   (rx_enable),
        .irq_enable  (irq_enable),
        .s_valid     (s_valid),
        .s_last      (s_last),
        .s_crc_ok    (s_crc_ok),
        .s_ready     (s_ready),
        .slot_addr   (ring_ptr),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_gnt     (mem_gnt),
        .mem_rdata   (mem_rdata),
        .pk_start    (pk_start),
        .pk_take     (pk_take),
        .pk_flush    (pk_flush),
        .pk_word     (pk_word),
        .pk_fill     (pk_fill),
        .pk_room     (pk_room),
        .pk_count    (pk_count),
        .pk_trunc    (pk_trunc),
        .ptr_advance (ptr_advance),
        .ptr_wrap    (ptr_wrap),
        .status_clr  (rx_status_clr),
        .status      (rx_status),
        .irq_pulse   (irq_pulse)
    );
endmodule

// File: rtl/rxring_dma_chk.sv
module rxring_dma_chk #(
    parameter int AW    = 32,
    parameter int OFS_W = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ring_ptr_wr,
    input logic [AW-1:0] ring_ptr,
    input logic          s_ready,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_gnt,
    input logic          rx_status,
    input logic          irq_pulse
);
    localparam logic [OFS_W-1:0] STEP = OFS_W'(8);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R2

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R3

    AST_NO_STREAM_WITH_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_ready && mem_req)); // R3

    AST_PTR_MOVES_LEGALLY: assert property (@(posedge clk) disable iff (!rst_n)
        !ring_ptr_wr |=> ((ring_ptr == $past(ring_ptr)) ||
                          ((ring_ptr[AW-1:OFS_W] == $past(ring_ptr[AW-1:OFS_W])) &&
                           ((ring_ptr[OFS_W-1:0] == '0) ||
                            (ring_ptr[OFS_W-1:0] == $past(ring_ptr[OFS_W-1:0]) + STEP))))); // R6

    AST_IRQ_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> rx_status); // R7

    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse); // R8
endmodule

bind rxring_dma rxring_dma_chk #(.AW(AW), .OFS_W(OFS_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ring_ptr_wr (ring_ptr_wr),
    .ring_ptr    (ring_ptr),
    .s_ready     (s_ready),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_gnt     (mem_gnt),
    .rx_status   (rx_status),
    .irq_pulse   (irq_pulse)
);

// File: tb/rxring_dma_tb_top.sv
`timescale 1ns/1ps
module rxring_dma_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_enable = 1'b0, irq_enable = 1'b0;
    logic        ring_ptr_wr = 1'b0;
    logic [31:0] ring_ptr_wdata = '0;
    logic [31:0] ring_ptr;
    logic        s_valid = 1'b0, s_last = 1'b0, s_crc_ok = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_gnt = 1'b0;
    logic        rx_status, irq_pulse;
    logic        rx_status_clr = 1'b0;

    always #4 clk = ~clk;

    rxring_dma dut_i (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .irq_enable(irq_enable),
        .ring_ptr_wr(ring_ptr_wr), .ring_ptr_wdata(ring_ptr_wdata), .ring_ptr(ring_ptr),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_crc_ok(s_crc_ok),
        .s_ready(s_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .rx_status(rx_status), .rx_status_clr(rx_status_clr), .irq_pulse(irq_pulse)
    );

    // Memory model: 4 KiB, grant after a varying delay, read data valid with grant.
    logic [31:0] tb_mem [1024];
    logic [1:0]  stall_q = '0;
    assign mem_rdata = tb_mem[mem_addr[11:2]];
    always @(posedge clk) begin
        stall_q <= stall_q + 2'd1;
        mem_gnt <= mem_req && !mem_gnt && (stall_q != 2'd0);
        if (mem_req && mem_we && mem_gnt) tb_mem[mem_addr[11:2]] = mem_wdata;
    end

    int irq_cnt = 0, txn_cnt = 0;
    always @(negedge clk) begin
        if (irq_pulse) irq_cnt++;
        if (mem_req && mem_gnt) txn_cnt++;
    end

    int compared = 0, mismatched = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pbyte(input logic [7:0] seed, input int i);
        return seed + 8'(i * 13);
    endfunction

    task automatic put_byte(input logic [7:0] d, input logic last, input logic crc);
        logic ok;
        s_valid = 1'b1; s_data = d; s_last = last; s_crc_ok = crc;
        forever begin
            ok = s_ready;
            @(negedge clk);
            if (ok) break;
        end
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic send_frame(input int len, input logic crc, input logic [7:0] seed);
        for (int i = 0; i < len; i++) put_byte(pbyte(seed, i), i == len - 1, crc);
        repeat (30) @(negedge clk);
    endtask

    task automatic load_ptr(input logic [31:0] v);
        ring_ptr_wr = 1'b1; ring_ptr_wdata = v;
        @(negedge clk);
        ring_ptr_wr = 1'b0;
    endtask

    task automatic clear_status();
        rx_status_clr = 1'b1;
        @(negedge clk);
        rx_status_clr = 1'b0;
    endtask

    // Compares the stored words, zero-filled past the frame end (R3).
    task automatic chk_buffer(input string req, input logic [31:0] buf_a, input int len, input logic [7:0] seed);
        int bad = 0;
        logic [31:0] expw, actw;
        for (int w = 0; w < (len + 3) / 4; w++) begin
            expw = '0;
            for (int l = 0; l < 4; l++)
                if (w * 4 + l < len) expw[l*8 +: 8] = pbyte(seed, w * 4 + l);
            actw = tb_mem[(buf_a >> 2) + w];
            if (actw !== expw && bad == 0) begin
                bad = 1;
                chk(req, "buffer word", actw, expw);
            end
        end
        if (bad == 0) chk(req, "buffer", 32'd0, 32'd0);
    endtask

    typedef struct packed {
        logic [11:0] len;
        logic        crc;
        logic        own;
        logic        wrap;
        logic        ie;
        logic        rxen;
        logic        irqen;
        logic        exp_store;
        logic        exp_irq;
        logic [7:0]  seed;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{12'd10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h11},
        '{12'd4,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h22},
        '{12'd1,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h33},
        '{12'd7,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h44},
        '{12'd6,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h55},
        '{12'd5,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h66},
        '{12'd64, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h77},
        '{12'd3,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h88}
    };

    localparam logic [31:0] RING = 32'h0000_0400;
    logic [9:0] off_m = '0;

    // Places a descriptor at the current slot with junk in the length and error bits.
    task automatic put_desc(input logic own, input logic wrap, input logic ie,
                            input logic [31:0] buf_a, output logic [31:0] w0);
        w0 = 32'h0001_0123 | (32'(own) << 11) | (32'(wrap) << 12) | (32'(ie) << 13);
        tb_mem[(RING | 32'(off_m)) >> 2]       = w0;
        tb_mem[((RING | 32'(off_m)) >> 2) + 1] = buf_a | 32'h3;
        for (int k = 0; k < 32; k++) tb_mem[(buf_a >> 2) + k] = 32'hA5A5_A5A5;
    endtask

    initial begin
        for (int k = 0; k < 1024; k++) tb_mem[k] = '0;
        repeat (3) @(negedge clk);
        chk("R10", "ring_ptr at reset", ring_ptr, 32'h0);
        chk("R10", "rx_status at reset", 32'(rx_status), 32'h0);
        chk("R10", "irq at reset", 32'(irq_pulse), 32'h0);
        chk("R10", "mem_req at reset", 32'(mem_req), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "s_ready after reset", 32'(s_ready), 32'h0);
        load_ptr(RING);

        for (int v = 0; v < NV; v++) begin
            vec_t t;
            logic [31:0] buf_a, w0;
            logic [9:0] slot;
            int irq0, txn0;
            string tag;
            t     = VECS[v];
            buf_a = (v % 2 == 1) ? 32'h0000_0C00 : 32'h0000_0800;
            slot  = off_m;
            put_desc(t.own, t.wrap, t.ie, buf_a, w0);
            rx_enable = t.rxen; irq_enable = t.irqen;
            clear_status();
            irq0 = irq_cnt; txn0 = txn_cnt;
            send_frame(int'(t.len), t.crc, t.seed);
            if (t.exp_store) off_m = (t.wrap || off_m == 10'h3F8) ? 10'h0 : off_m + 10'd8;
            tag = !t.rxen ? "R1" : (!t.own ? "R2" : (!t.crc ? "R4" : "R6"));
            chk(tag, "ring_ptr", ring_ptr, RING | 32'(off_m));
            chk(t.exp_store ? "R7" : tag, "rx_status", 32'(rx_status), 32'(t.exp_store));
            chk(t.exp_store ? "R8" : tag, "irq pulses", 32'(irq_cnt - irq0), 32'(t.exp_irq));
            if (t.exp_store) begin
                chk("R5", "word0", tb_mem[(RING | 32'(slot)) >> 2], 32'(t.len) | (32'(t.ie) << 13));
                chk("R5", "word1", tb_mem[((RING | 32'(slot)) >> 2) + 1], buf_a);
                chk_buffer("R3", buf_a, int'(t.len), t.seed);
            end else begin
                chk(tag, "word0 untouched", tb_mem[(RING | 32'(slot)) >> 2], w0);
                if (!t.rxen) chk("R1", "memory transactions", 32'(txn_cnt - txn0), 32'd0);
                if (!t.own)  chk("R2", "memory transactions", 32'(txn_cnt - txn0), 32'd2);
            end
        end

        // R6: last slot of the ring returns to offset 0 without a wrap flag.
        begin
            logic [31:0] w0;
            rx_enable = 1'b1; irq_enable = 1'b1;
            load_ptr(RING | 32'h3F8);
            off_m = 10'h3F8;
            put_desc(1'b1, 1'b0, 1'b1, 32'h0000_0800, w0);
            clear_status();
            send_frame(8, 1'b1, 8'h9A);
            chk("R6", "offset after 0x3F8", ring_ptr, RING);
            chk("R3", "word at 0x800", tb_mem[32'h800 >> 2], {pbyte(8'h9A,3), pbyte(8'h9A,2), pbyte(8'h9A,1), pbyte(8'h9A,0)});
        end

        // R7: status clears on request.
        chk("R7", "status set before clear", 32'(rx_status), 32'h1);
        clear_status();
        chk("R7", "status after clear", 32'(rx_status), 32'h0);

        // R9: truncation at 2047 bytes.
        begin
            logic [31:0] w0;
            off_m = 10'h0;
            put_desc(1'b1, 1'b0, 1'b0, 32'h0000_0800, w0);
            send_frame(2050, 1'b1, 8'h05);
            chk("R9", "truncated word0", tb_mem[RING >> 2], 32'h0000_87FF);
            chk("R9", "final word", tb_mem[(32'h800 + 2044) >> 2],
                {8'h00, pbyte(8'h05, 2046), pbyte(8'h05, 2045), pbyte(8'h05, 2044)});
            chk("R9", "ring_ptr after truncated frame", ring_ptr, RING | 32'h8);
        end

        // R6: a load sets base and offset together.
        load_ptr(32'hABCD_E410);
        chk("R6", "loaded pointer", ring_ptr, 32'hABCD_E410);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule